// File: doc/BRIEF.md
# Low-Frequency Reference and Tick Generator

This block produces the slow reference clock level that a chip uses while the processor sleeps, and from it a periodic tick that sets the step size of the watchdog and the wakeup timer. The reference is nominally 4 kHz. It comes from one of two places. While the crystal runs, a counter clocked by the fast sampling clock `clk` divides the crystal down. When the crystal is absent, the reference follows an RC oscillator input that is always running. The RC input is brought into the `clk` domain through two flops.

A small register file holds three things: an 8-bit tick divider, a 6-bit clock-setup word, and a read-only status bit that shows the present level of the reference. The clock-setup word selects the crystal division ratio. Its fields are a 3-bit frequency code, a flag that bypasses the prescaler, and a 2-bit prescaler code. Each tick lasts (1 + divider) reference periods. A change to the divider is only picked up at a tick, so the tick in progress always runs to its full length.

A state machine switches between the two sources without glitches. It moves through six states:
- `ARM_RC` waits for the RC level to be low, then goes to `RUN_RC`.
- `RUN_RC` goes to `DRAIN_RC` when the crystal starts.
- `DRAIN_RC` waits for the RC level to be low, then goes to `ARM_XT`.
- `ARM_XT` goes to `RUN_XT` when the crystal level is low and the crystal is running. If the crystal stops while in `ARM_XT`, it returns to `ARM_RC`.
- `RUN_XT` goes to `DRAIN_XT` when the crystal stops.
- `DRAIN_XT` waits for the crystal level to be low, then goes to `ARM_RC`.

The reset state is `ARM_RC`.

Top module: `lf_tick_gen`

## Requirements
- R1: After reset, address 0 reads 0x03, address 1 reads 0x27 and address 3 reads 0x00.
- R2: The register addresses are:
  - Address 0 is the 8-bit divider.
  - Address 1 is the 6-bit setup word, with bits 7:6 reading as zero.
  - Address 2 is read-only status: bit 0 equals `lf_level` and bits 7:1 read zero.
  - Writes to addresses 2 and 3 change no register.
- R3: `tick` is a single `clk`-cycle pulse on a rising edge of the reference. Consecutive ticks are (1 + divider) reference periods apart.
- R4: A divider write takes effect only after the next tick. The tick period during which the write happens keeps the old length.
- R5: With a running crystal, each reference phase lasts HALF_UNIT·(f+1)·k `clk` cycles. Here f is setup bits 5:3, and k is 1 when bit 2 is set or (p+1) otherwise, where p is bits 1:0. With HALF_UNIT = 4, setup word 0x27 gives a 40-cycle reference.
- R6: A frequency code of 5, 6 or 7 selects the reset setting, which is a 20-cycle phase with the default HALF_UNIT.
- R7: While `xtal_run` is low, the reference follows the synchronised `rc_osc`. The tick spacing is then (1 + divider) RC periods. When the crystal returns, the reference goes back to the crystal.
- R8: Source changes are glitch-free. At most one source is enabled at a time. A source is disabled only while its level is low, and a new one is enabled only after the output is low. No high phase of `lf_level` is cut short.
- R9: A divider value of 0 gives one tick on every reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, standing in for the crystal |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_run | input | 1 | High while the crystal clock is available |
| rc_osc | input | 1 | Free-running RC oscillator, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| lf_level | output | 1 | Selected, gated reference level |
| tick | output | 1 | Tick pulse, one `clk` cycle wide |

## Verification
The assertions assume the following about the inputs:
- `rc_osc` stays in each phase for several `clk` cycles, so a synchronised rising edge can never repeat on back-to-back cycles.
- `xtal_run` drops only while the crystal-derived level is low. This is because the crystal divider is forced low the moment the crystal stops.

The stimulus respects both assumptions:
- `rc_osc` toggles every 15 cycles, with its edges offset from the clock.
- The bench lowers `xtal_run` only after it has seen `lf_level` low.
- Every configuration used keeps each reference phase at least four cycles long.

// File: rtl/lft_pkg.sv
`timescale 1ns/1ps
package lft_pkg;

    localparam logic [7:0] DIV_RST  = 8'h03;
    localparam logic [5:0] CFG_RST  = 6'h27;
    localparam int unsigned MAX_FREQ = 4;

    typedef enum logic [2:0] {
        ARM_RC,
        RUN_RC,
        DRAIN_RC,
        ARM_XT,
        RUN_XT,
        DRAIN_XT
    } src_state_t;

    typedef struct packed {
        logic [2:0] freq;
        logic       direct;
        logic [1:0] presc;
    } lf_cfg_t;

    // Phase length in clk cycles for a given setup word.
    function automatic int unsigned half_cycles(input logic [5:0] raw, input int unsigned unit);
        lf_cfg_t c;
        int unsigned k;
        c = raw;
        if (int'(c.freq) > MAX_FREQ) c = CFG_RST;
        k = c.direct ? 1 : (int'(c.presc) + 1);
        return unit * (int'(c.freq) + 1) * k;
    endfunction

endpackage

// File: rtl/lft_regs.sv
`timescale 1ns/1ps
module lft_regs
    import lft_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CFG_W = 6
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             lf_level,
    output logic [DIV_W-1:0] div_reg,
    output logic [CFG_W-1:0] cfg_reg,
    output logic [7:0]       rdata
);
    typedef enum logic [1:0] {
        REG_DIV  = 2'd0,
        REG_CFG  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_t;

    reg_sel_t sel;
    assign sel = reg_sel_t'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_reg <= DIV_W'(DIV_RST);
            cfg_reg <= CFG_W'(CFG_RST);
        end else if (wr_en) begin
            unique case (sel)
                REG_DIV:  div_reg <= wdata[DIV_W-1:0];
                REG_CFG:  cfg_reg <= wdata[CFG_W-1:0];
                REG_STAT: ;
                REG_NONE: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_DIV:  rdata[DIV_W-1:0] = div_reg;
            REG_CFG:  rdata[CFG_W-1:0] = cfg_reg;
            REG_STAT: rdata[0]         = lf_level;
            REG_NONE: rdata            = '0;
        endcase
    end

    // R2: a write to the status or unused address leaves both registers alone
    a_r2_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr[1]) |-> ($stable(div_reg) && $stable(cfg_reg)));

endmodule

// File: rtl/lft_xtal_div.sv
`timescale 1ns/1ps
module lft_xtal_div #(
    parameter int HALF_W = 7
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              lvl
);
    logic [HALF_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (cnt >= half - 1'b1) begin
            cnt <= '0;
            lvl <= ~lvl;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: the phase counter never runs past the programmed length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(half) && $past(run)) |-> (cnt < half));

endmodule

// File: rtl/lft_src_sel.sv
`timescale 1ns/1ps
module lft_src_sel
    import lft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_run,
    input  logic xt_lvl,
    input  logic rc_osc,
    output logic lf_level
);
    logic [1:0] rc_sync;
    logic       rc_lvl;
    src_state_t state, state_nx;
    logic       xt_en, rc_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rc_sync <= '0;
        else        rc_sync <= {rc_sync[0], rc_osc};
    end
    assign rc_lvl = rc_sync[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARM_RC;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ARM_RC:   if (!rc_lvl)               state_nx = RUN_RC;
            RUN_RC:   if (xtal_run)              state_nx = DRAIN_RC;
            DRAIN_RC: if (!rc_lvl)               state_nx = ARM_XT;
            ARM_XT: begin
                if (!xtal_run)                   state_nx = ARM_RC;
                else if (!xt_lvl)                state_nx = RUN_XT;
            end
            RUN_XT:   if (!xtal_run)             state_nx = DRAIN_XT;
            DRAIN_XT: if (!xt_lvl)               state_nx = ARM_RC;
            default:                             state_nx = ARM_RC;
        endcase
    end

    always_comb begin
        xt_en = 1'b0;
        rc_en = 1'b0;
        unique case (state)
            RUN_RC, DRAIN_RC: rc_en = 1'b1;
            RUN_XT, DRAIN_XT: xt_en = 1'b1;
            default: ;
        endcase
        lf_level = (xt_en & xt_lvl) | (rc_en & rc_lvl);
    end

    // R8: never two sources at once
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xt_en, rc_en}));
    // R8: a source is removed only while the output is low
    a_r8_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(xt_en) || $fell(rc_en)) |-> !$past(lf_level));
    // R8: a source is connected only after a cycle with the output low
    a_r8_enable_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xt_en) || $rose(rc_en)) |-> !$past(lf_level));
    // R7: crystal path is connected only when the crystal was running
    a_r7_xt_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xt_en) |-> $past(xtal_run));

endmodule

// File: rtl/lft_tick_div.sv
`timescale 1ns/1ps
module lft_tick_div #(
    parameter int DIV_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lf_level,
    input  logic [DIV_W-1:0] div_reg,
    input  logic [DIV_W-1:0] div_rst,
    output logic             tick
);
    logic             lf_prev;
    logic             rise;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_act;

    assign rise = lf_level & ~lf_prev;
    assign tick = rise & (cnt == div_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lf_prev <= 1'b0;
            cnt     <= '0;
            div_act <= div_rst;
        end else begin
            lf_prev <= lf_level;
            if (rise) begin
                if (cnt == div_act) begin
                    cnt     <= '0;
                    div_act <= div_reg;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R3: a tick lasts exactly one clk cycle
    a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R3: a tick only ever follows a low reference level
    a_r3_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (lf_level && !$past(lf_level)));
    // R4: the active divider changes only right after a tick
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (div_act != $past(div_act)) |-> $past(tick));
    // R9: the edge counter stays within the active divider
    a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div_act);

endmodule

// File: rtl/lf_tick_gen.sv
`timescale 1ns/1ps
module lf_tick_gen
    import lft_pkg::*;
#(
    parameter int HALF_UNIT = 4
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xtal_run,
    input  logic       rc_osc,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       lf_level,
    output logic       tick
);
    localparam int DIV_W    = 8;
    localparam int CFG_W    = 6;
    localparam int HALF_MAX = HALF_UNIT * (MAX_FREQ + 1) * 4;
    localparam int HALF_W   = $clog2(HALF_MAX + 1);

    logic [DIV_W-1:0]  div_reg;
    logic [CFG_W-1:0]  cfg_reg;
    logic [HALF_W-1:0] half;
    logic              xt_lvl;

    assign half = HALF_W'(half_cycles(cfg_reg, HALF_UNIT));

    lft_regs #(.DIV_W(DIV_W), .CFG_W(CFG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .lf_level (lf_level),
        .div_reg  (div_reg),
        .cfg_reg  (cfg_reg),
        .rdata    (rdata)
    );

    lft_xtal_div #(.HALF_W(HALF_W)) u_xdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (xtal_run),
        .half  (half),
        .lvl   (xt_lvl)
    );

    lft_src_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .xtal_run (xtal_run),
        .xt_lvl   (xt_lvl),
        .rc_osc   (rc_osc),
        .lf_level (lf_level)
    );

    lft_tick_div #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .lf_level (lf_level),
        .div_reg  (div_reg),
        .div_rst  (DIV_W'(DIV_RST)),
        .tick     (tick)
    );

endmodule

// File: tb/lf_tick_gen_test.sv
`timescale 1ns/1ps
module lf_tick_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal_run = 1'b1;
    logic       rc_osc = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       lf_level;
    logic       tick;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_t = 0;
    bit have_last = 1'b0;
    bit done = 1'b0;
    int hi_len = 0;
    int short_hi = 0;
    int unsigned exp_q[$];
    string tag_q[$];

    lf_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .xtal_run(xtal_run), .rc_osc(rc_osc),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .lf_level(lf_level), .tick(tick)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        #2;
        forever #75 rc_osc = ~rc_osc;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: tick spacing against the scoreboard, and high-phase lengths.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tick) begin
                if (have_last && exp_q.size() > 0)
                    check(tag_q.pop_front(), cyc - last_t, int'(exp_q.pop_front()));
                last_t = cyc;
                have_last = 1'b1;
            end
            if (lf_level) hi_len++;
            else begin
                if (hi_len > 0 && hi_len < 4) short_hi++;
                hi_len = 0;
            end
        end
    end

    task automatic wait_tick();
        do @(negedge clk); while (!tick);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, int'(rdata), int'(exp));
    endtask

    task automatic drain_q();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    // Driver: settle, then queue n expected intervals and let the monitor score them.
    task automatic expect_ticks(input string req, input int iv, input int n);
        wait_tick(); wait_tick(); wait_tick();
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(iv);
            tag_q.push_back(req);
        end
        drain_q();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd_check("R1 div", 2'd0, 8'h03);
        rd_check("R1 cfg", 2'd1, 8'h27);
        rd_check("R1 unused", 2'd3, 8'h00);
        // R5 and R3 at reset setting: phase 20, period 40, four periods
        expect_ticks("R5/R3 reset", 160, 3);
        // R9 divider zero
        wr(2'd0, 8'd0);
        expect_ticks("R9 div0", 40, 3);
        // R5 prescaled: freq 1, no bypass, presc 1 -> phase 16
        wr(2'd1, 8'h09);
        wr(2'd0, 8'd2);
        expect_ticks("R5 presc", 96, 3);
        // R6 freq code 6 falls back to phase 20
        wr(2'd1, 8'h30);
        wr(2'd0, 8'd1);
        expect_ticks("R6 fallback", 80, 3);
        // R2 upper setup bits read zero; freq 7 also falls back (R6)
        wr(2'd1, 8'hFF);
        rd_check("R2 cfg width", 2'd1, 8'h3F);
        expect_ticks("R6 freq7", 80, 2);
        // R2 status is read-only and mirrors lf_level
        wr(2'd2, 8'hAA);
        wr(2'd3, 8'h55);
        rd_check("R2 div kept", 2'd0, 8'h01);
        rd_check("R2 cfg kept", 2'd1, 8'h3F);
        for (int i = 0; i < 4; i++) begin
            repeat (7) @(negedge clk);
            addr = 2'd2;
            #1;
            check("R2 status", int'(rdata), int'({7'd0, lf_level}));
        end
        // R4 divider change waits for the tick boundary: bypass, freq 0 -> period 8
        wr(2'd1, 8'h07);
        wr(2'd0, 8'd5);
        expect_ticks("R4 pre", 48, 2);
        wait_tick();
        exp_q.push_back(48); tag_q.push_back("R4 old kept");
        exp_q.push_back(16); tag_q.push_back("R4 new used");
        repeat (10) @(negedge clk);
        addr = 2'd0; wdata = 8'd1; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        drain_q();
        // R7 RC source when the crystal stops
        wr(2'd1, 8'h27);
        wr(2'd0, 8'd3);
        expect_ticks("R7 xtal", 160, 1);
        do @(negedge clk); while (lf_level);
        xtal_run = 1'b0;
        expect_ticks("R7 rc", 120, 3);
        xtal_run = 1'b1;
        expect_ticks("R7 back", 160, 2);
        // R8 no shortened high phase across all switches
        check("R8 short high phases", short_hi, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule